// File: doc/BRIEF.md
# PHY Register Scan and Link Monitor

This block sits on top of a serial management (MDIO) master and keeps a software-free view of one Ethernet PHY. At reset, and again each time a long interval timer wraps, it walks the whole 32-entry management register space of the selected PHY. It reads one register at a time, in ascending order, and keeps a shadow copy of every result in a local array. The array can be read at any time through a combinational read port.

Reads are paced by an external tick enable, nominally 100 kHz. A new request is only issued after the MDIO master has returned the previous result, so the scan can never run ahead of the bus. Whenever the basic status register (register 1) is returned, the block extracts two flags: link-up from bit 2 and auto-negotiation-complete from bit 5. It raises a one-cycle pulse when either flag differs from the value held since the previous sweep. This gives link supervision logic a single event to react to.

Top module: `phy_scan_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `rd_req`, `link_up`, `an_done` and `status_chg` are all 0.
- R2: A sweep starts in the cycle after reset and then every `SWEEP_CYCLES` clock cycles. It requests registers 0,1,...,31 in ascending order, exactly once each. A start that arrives while a sweep is still running is dropped.
- R3: `rd_req` is a one-cycle pulse. It is raised only in the cycle after `tick` was sampled high, and never while an earlier request is still waiting for `rd_ready`.
- R4: `rd_phy` carries the value of `phy_addr` that was sampled together with the tick that launched the request.
- R5: When `rd_ready` is high for an outstanding request, `rd_data` is stored in the shadow entry of the requested register. From the next cycle on, `sh_data` returns that value for `sh_addr` equal to that register number.
- R6: A `rd_ready` pulse that arrives when no request is outstanding changes no shadow entry and no flag.
- R7: On completion of register 1, `link_up` takes bit 2 and `an_done` takes bit 5 of the returned data. For example, 0x7949 gives 0/0, 0x796D gives 1/1, and 0x7969 gives 0/1. Both flags hold their values between completions of register 1.
- R8: `status_chg` pulses for exactly one cycle, in the cycle the flags update, when the new `link_up` or `an_done` differs from its previous value. It stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Pacing enable, one read may be issued per tick |
| phy_addr | input | 5 | Management address of the monitored PHY |
| rd_ready | input | 1 | Read-complete pulse from the MDIO master |
| rd_data | input | 16 | Read result from the MDIO master, valid with rd_ready |
| rd_req | output | 1 | One-cycle read request to the MDIO master |
| rd_phy | output | 5 | PHY address for the request |
| rd_reg | output | 5 | Register number for the request |
| sh_addr | input | 5 | Shadow array read address |
| sh_data | output | 16 | Shadow array read data (combinational) |
| link_up | output | 1 | Decoded link-up flag |
| an_done | output | 1 | Decoded auto-negotiation-complete flag |
| status_chg | output | 1 | One-cycle pulse when either flag changes |

## Verification
On every cycle, the embedded properties check the following: request pulse width, that each request follows a tick, that the request address follows `phy_addr`, that stores land in the requested entry, that the timer wraps into a sweep start, that the flags stay stable outside register 1 completions, and that each change pulse goes with an actual flag change. Only the bench scenarios can show the rest. These are the ascending register order across a whole sweep, the sweep-to-sweep spacing, and that the full shadow array matches a randomized PHY image after each sweep. They also cover that stray completion pulses between sweeps leave the state alone, and the exact number of change pulses across the sequence 0x7949, 0x796D, 0x796D, 0x7969.

// File: rtl/scan_pkg.sv
// Package: shared constants and types for the PHY register scanner.
// Assumes a 32-entry, 16-bit management register space.
package scan_pkg;
    localparam int STATUS_REG = 1;   // basic status register number
    localparam int LINK_BIT   = 2;   // link-up flag position
    localparam int AN_BIT     = 5;   // auto-negotiation-complete position

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ISSUE = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/scan_interval_timer.sv
// Module: free-running interval timer that emits a sweep start when it is at zero.
// Assumes PERIOD >= 2; the first start occurs in the first cycle after reset.
module scan_interval_timer #(
    parameter int PERIOD = 75_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic sweep_start
);
    localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [CW-1:0] cnt;

    // Count 0..PERIOD-1 and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == CW'(PERIOD - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign sweep_start = (cnt == '0);

    p_wrap_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(PERIOD - 1)) |=> sweep_start);
endmodule

// File: rtl/scan_sequencer.sv
// Module: steps through the register numbers, one outstanding read at a time.
// Assumes rd_ready arrives at least one cycle after rd_req; ready while idle is ignored.
module scan_sequencer
    import scan_pkg::*;
#(
    parameter int NREG = 32,
    parameter int AW   = 5,
    parameter int DW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sweep_start,
    input  logic          tick,
    input  logic [4:0]    phy_addr,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic [4:0]    rd_phy,
    output logic [AW-1:0] rd_reg,
    output logic          wr_en,
    output logic [AW-1:0] wr_idx,
    output logic [DW-1:0] wr_data
);
    seq_state_t    state;
    logic [AW-1:0] idx;

    // Sweep state machine: idle -> issue on tick -> wait for ready -> next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= SEQ_IDLE;
            idx    <= '0;
            rd_req <= 1'b0;
            rd_reg <= '0;
            rd_phy <= '0;
        end else begin
            rd_req <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (sweep_start) begin
                        idx   <= '0;
                        state <= SEQ_ISSUE;
                    end
                end
                SEQ_ISSUE: begin
                    if (tick) begin
                        rd_req <= 1'b1;
                        rd_reg <= idx;
                        rd_phy <= phy_addr;
                        state  <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (rd_ready) begin
                        if (idx == AW'(NREG - 1)) begin
                            state <= SEQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SEQ_ISSUE;
                        end
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Store strobe toward the shadow array, only for an outstanding read.
    assign wr_en   = (state == SEQ_WAIT) && rd_ready;
    assign wr_idx  = idx;
    assign wr_data = rd_data;

    p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    p_req_after_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> $past(tick));
    p_req_phy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req) |-> (rd_phy == $past(phy_addr)));
    p_store_index_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx == rd_reg));
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> !rd_req);
endmodule

// File: rtl/scan_shadow_regs.sv
// Module: shadow copy of the PHY register space with one combinational read port.
// Assumes a single write per cycle; entries clear to zero on reset.
module scan_shadow_regs #(
    parameter int NREG = 32,
    parameter int AW   = 5,
    parameter int DW   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_dout
);
    logic [DW-1:0] mem [NREG];

    // Clear on reset, otherwise store the returned read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_dout = mem[rd_addr];

    p_store_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_data)));
endmodule

// File: rtl/scan_status_decode.sv
// Module: extracts link and auto-negotiation flags from the status register
// and pulses on any flag change. Assumes writes arrive via the shadow strobe.
module scan_status_decode
    import scan_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    output logic          link_up,
    output logic          an_done,
    output logic          status_chg
);
    logic hit;
    assign hit = wr_en && (wr_idx == AW'(STATUS_REG));

    // Capture flags from register 1 and flag any difference.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link_up    <= 1'b0;
            an_done    <= 1'b0;
            status_chg <= 1'b0;
        end else begin
            status_chg <= 1'b0;
            if (hit) begin
                link_up    <= wr_data[LINK_BIT];
                an_done    <= wr_data[AN_BIT];
                status_chg <= (wr_data[LINK_BIT] != link_up) ||
                              (wr_data[AN_BIT]   != an_done);
            end
        end
    end

    p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(link_up) && $stable(an_done)));
    p_chg_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |-> ((link_up != $past(link_up)) || (an_done != $past(an_done))));
    p_chg_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_chg |=> !status_chg);
endmodule

// File: rtl/phy_scan_monitor.sv
// Module: top of the PHY register scanner and link monitor. Sweeps all
// registers of one PHY at a fixed interval through an external MDIO master.
// Assumes the master answers every request with exactly one rd_ready pulse.
module phy_scan_monitor #(
    parameter int NREG         = 32,
    parameter int DW           = 16,
    parameter int SWEEP_CYCLES = 75_000_000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [4:0]    phy_addr,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          rd_req,
    output logic [4:0]    rd_phy,
    output logic [4:0]    rd_reg,
    input  logic [4:0]    sh_addr,
    output logic [DW-1:0] sh_data,
    output logic          link_up,
    output logic          an_done,
    output logic          status_chg
);
    localparam int AW = 5;

    logic          sweep_start;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic [DW-1:0] wr_data;

    scan_interval_timer #(.PERIOD(SWEEP_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start)
    );

    scan_sequencer #(.NREG(NREG), .AW(AW), .DW(DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .sweep_start(sweep_start), .tick(tick),
        .phy_addr(phy_addr), .rd_ready(rd_ready), .rd_data(rd_data),
        .rd_req(rd_req), .rd_phy(rd_phy), .rd_reg(rd_reg),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
    );

    scan_shadow_regs #(.NREG(NREG), .AW(AW), .DW(DW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_addr(sh_addr), .rd_dout(sh_data)
    );

    scan_status_decode #(.AW(AW), .DW(DW)) u_status (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .link_up(link_up), .an_done(an_done),
        .status_chg(status_chg)
    );

    p_reset_flags_r1: assert property (@(posedge clk)
        !rst_n |=> (!link_up && !an_done && !status_chg));
endmodule

// File: tb/sim_phy_scan_monitor.sv
module sim_phy_scan_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int SWEEP      = 2000;
    localparam int NREG       = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [4:0]  phy_addr = 5'd0;
    logic        rd_ready = 1'b0;
    logic [15:0] rd_data = 16'd0;
    logic        rd_req;
    logic [4:0]  rd_phy;
    logic [4:0]  rd_reg;
    logic [4:0]  sh_addr = 5'd0;
    logic [15:0] sh_data;
    logic        link_up, an_done, status_chg;

    int n_chk = 0, n_fail = 0;
    int cyc = 0;
    int exp_idx = 0, sweeps_done = 0;
    int chg_count = 0;
    int start_cyc [8];
    logic tick_at_edge = 1'b0;
    logic prev_chg = 1'b0;
    logic [15:0] mreg [NREG];

    phy_scan_monitor #(.NREG(NREG), .DW(16), .SWEEP_CYCLES(SWEEP)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .phy_addr(phy_addr),
        .rd_ready(rd_ready), .rd_data(rd_data), .rd_req(rd_req),
        .rd_phy(rd_phy), .rd_reg(rd_reg), .sh_addr(sh_addr),
        .sh_data(sh_data), .link_up(link_up), .an_done(an_done),
        .status_chg(status_chg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] flags_of(input logic [15:0] v);
        return {v[5], v[2]};   // {an_done, link_up}
    endfunction

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    // cycle counter and tick sampled at each active edge
    initial forever begin
        @(posedge clk);
        cyc++;
        tick_at_edge = tick;
    end

    // tick generator with random gaps
    initial begin
        forever begin
            repeat ($urandom_range(4, 12)) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // change-pulse monitor
    initial forever begin
        @(negedge clk);
        if (status_chg) chg_count++;
        if (status_chg && prev_chg) chk("R8 pulse width", 32'd2, 32'd1);
        prev_chg = status_chg;
    end

    // MDIO master model
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req && rst_n) begin
                automatic logic [4:0] r = rd_reg;
                automatic int lat = $urandom_range(1, 6);
                chk("R2 register order", 32'(rd_reg), 32'(exp_idx));
                chk("R4 phy address", 32'(rd_phy), 32'(phy_addr));
                chk("R3 tick before request", 32'(tick_at_edge), 32'd1);
                if (exp_idx == 0 && sweeps_done < 8) start_cyc[sweeps_done] = cyc;
                repeat (lat) begin
                    @(negedge clk);
                    if (rd_req) chk("R3 request while outstanding", 32'd1, 32'd0);
                end
                rd_ready = 1'b1;
                rd_data  = mreg[r];
                @(negedge clk);
                rd_ready = 1'b0;
                rd_data  = 16'hxxxx;
                exp_idx++;
                if (exp_idx == NREG) begin
                    exp_idx = 0;
                    sweeps_done++;
                end
            end
        end
    end

    task automatic check_shadow(input string tag);
        for (int i = 0; i < NREG; i++) begin
            sh_addr = 5'(i);
            #1;
            if (sh_data !== mreg[i]) chk(tag, 32'(sh_data), 32'(mreg[i]));
        end
        n_chk++;
    endtask

    task automatic randomize_image(input logic [15:0] status);
        for (int i = 0; i < NREG; i++) mreg[i] = 16'($urandom);
        mreg[1] = status;
    endtask

    task automatic run_sweep(input int n, input logic [15:0] status, input int exp_chg);
        int c0;
        c0 = chg_count;
        wait (sweeps_done == n);
        @(negedge clk);
        check_shadow("R5 shadow image");
        chk("R7 flags", 32'({an_done, link_up}), 32'(flags_of(status)));
        chk("R8 change count", 32'(chg_count - c0), 32'(exp_chg));
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        summary();
    end

    initial begin
        logic [15:0] keep1, keep31;
        void'($urandom(32'h5eed_0123));
        randomize_image(16'h7949);
        // R1: reset state
        repeat (4) @(negedge clk);
        chk("R1 rd_req in reset", 32'(rd_req), 32'd0);
        chk("R1 flags in reset", 32'({link_up, an_done, status_chg}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", 32'({link_up, an_done, status_chg}), 32'd0);

        // sweep 1: no cable image
        run_sweep(1, 16'h7949, 0);

        // R6: stray completions between sweeps
        keep1  = mreg[1];
        keep31 = mreg[31];
        repeat (3) begin
            rd_ready = 1'b1;
            rd_data  = 16'hFFFF;
            @(negedge clk);
            rd_ready = 1'b0;
            @(negedge clk);
        end
        sh_addr = 5'd31; #1;
        chk("R6 entry 31 untouched", 32'(sh_data), 32'(keep31));
        sh_addr = 5'd1; #1;
        chk("R6 entry 1 untouched", 32'(sh_data), 32'(keep1));
        chk("R6 flags untouched", 32'({an_done, link_up, status_chg}), 32'd0);

        // sweep 2: link established
        randomize_image(16'h796D);
        run_sweep(2, 16'h796D, 1);

        // sweep 3: same status, no pulse
        randomize_image(16'h796D);
        run_sweep(3, 16'h796D, 0);
        // R2: sweep spacing
        chk("R2 sweep interval",
            32'((start_cyc[2] - start_cyc[1] >= SWEEP - 13) &&
                (start_cyc[2] - start_cyc[1] <= SWEEP + 13)), 32'd1);

        // sweep 4: link lost, auto-negotiation still complete, new phy address
        phy_addr = 5'($urandom_range(1, 31));
        randomize_image(16'h7969);
        run_sweep(4, 16'h7969, 1);
        chk("R2 sweep count", 32'(sweeps_done), 32'd4);

        summary();
    end
endmodule